// File: doc/BRIEF.md
# Smart Mailbox Interrupt Controller

This block is an array of 64-bit mailboxes that doubles as an interrupt source. A producer writes a value to a mailbox over a simple synchronous bus. The mailbox folds the value into its content in one of three ways: it replaces the content, ORs into it, or adds to it. The block then tests the updated content against a condition chosen for that mailbox. When the condition holds, the mailbox's bit in a sticky pending vector is set. A consumer watches that vector and clears bits by pulsing a dedicated acknowledge port with a mask.

Each mailbox has three parts: a content word, its own 64-bit trigger value, and a 4-bit configuration word that picks the update mode and the condition. There are four conditions:

- **Doorbell** fires on every write.
- **Equality** fires when the updated content equals the trigger value.
- **Rendezvous** is equality that also clears the content to zero when it fires.
- **Threshold** fires when the updated content is at least the trigger value, compared unsigned.

Only content writes are ever tested. Reads, trigger-value writes and configuration writes never raise an interrupt.

Top module: `smart_mailbox_irq`

## Requirements
- R1: After a synchronous active-low reset, every content word, trigger value, configuration word, the pending vector and `bus_rdata` are zero.
- R2: The address is `{region[1:0], index[6:0]}`. Region 0 selects content, region 1 selects the trigger value and region 2 selects configuration. Region 3 reads as zero and ignores writes. In a configuration word, bits [1:0] are the mode and bits [3:2] are the condition.
- R3: Mode 00 replaces the content with the written data.
- R4: Mode 01 sets the content to the old content OR the written data.
- R5: Mode 10 sets the content to old content plus written data, modulo 2^64, and the carry is lost.
- R6: Mode 11 behaves like mode 00.
- R7: Condition 00 sets the mailbox's pending bit on every content write, whatever value results.
- R8: Condition 01 sets the pending bit when the updated content equals the trigger value.
- R9: Condition 10 sets the pending bit like condition 01, and the stored content becomes zero on the same clock edge.
- R10: Condition 11 sets the pending bit when the updated content is greater than or equal to the trigger value, unsigned.
- R11: Only region-0 writes set pending bits. Reads and writes to the trigger and configuration regions leave the pending vector and the content unchanged.
- R12: A pending bit stays set until `ack_valid` is high with the matching `ack_bits` bit set. If a set and an acknowledge of the same bit fall on the same edge, the bit ends up set.
- R13: A read returns the addressed word on `bus_rdata` one cycle later and changes no state. `bus_rdata` holds its value when no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | {region, mailbox index} |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, one cycle after the read |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_bits | input | 128 | Mask of pending bits to clear |
| irq_pending | output | 128 | Sticky pending bit per mailbox |

## Verification
A trigger that fires and an acknowledge of the same mailbox can land on the same clock edge. When they do, the set must win.

The bench provokes this in two ways:
- A directed case pulses `ack_bits` for a doorbell mailbox in the very cycle that mailbox is written.
- The random phase often raises an acknowledge mask over the active low-numbered mailboxes while a content write is in flight.

After every cycle, the whole pending vector is compared with a bench model. That model clears the acknowledged bits first and then ORs in the bit for any trigger that fired.

// File: rtl/mbx_pkg.sv
// Shared types for the smart mailbox block.
// Assumes: configuration packs the condition above the mode in 4 bits.
package mbx_pkg;

    typedef enum logic [1:0] {
        MODE_REPLACE = 2'b00,
        MODE_OR      = 2'b01,
        MODE_ADD     = 2'b10,
        MODE_SPARE   = 2'b11
    } upd_mode_e;

    typedef enum logic [1:0] {
        COND_DOORBELL = 2'b00,
        COND_EQUAL    = 2'b01,
        COND_RENDEZ   = 2'b10,
        COND_AT_LEAST = 2'b11
    } trig_cond_e;

    typedef enum logic [1:0] {
        RGN_CONTENT = 2'b00,
        RGN_TRIGGER = 2'b01,
        RGN_CONFIG  = 2'b10,
        RGN_NONE    = 2'b11
    } region_e;

    typedef struct packed {
        trig_cond_e cond;
        upd_mode_e  mode;
    } box_cfg_t;

endpackage

// File: rtl/mbx_decode.sv
// Bus decoder: splits a bus access into per-region strobes and an index.
// Assumes: one access per cycle; out-of-range indices produce no strobe.
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int NUM_BOX = 128,
    localparam int IDX_W  = $clog2(NUM_BOX),
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [IDX_W-1:0]  idx,
    output region_e           region,
    output logic              content_wr,
    output logic              trigger_wr,
    output logic              config_wr,
    output logic              rd
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_BOX);

    logic idx_ok;

    // Split the address and qualify the index against the mailbox count.
    always_comb begin
        idx        = bus_addr[IDX_W-1:0];
        region     = region_e'(bus_addr[ADDR_W-1:IDX_W]);
        idx_ok     = ({1'b0, idx} < LIMIT);
        content_wr = bus_en && bus_we && idx_ok && (region == RGN_CONTENT);
        trigger_wr = bus_en && bus_we && idx_ok && (region == RGN_TRIGGER);
        config_wr  = bus_en && bus_we && idx_ok && (region == RGN_CONFIG);
        rd         = bus_en && !bus_we;
    end
endmodule

// File: rtl/mbx_update.sv
// Update datapath: applies the input mode, then evaluates the trigger condition
// on the post-update value. Purely combinational.
// Assumes: unsigned arithmetic; addition wraps at the data width.
module mbx_update
    import mbx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] trig,
    input  box_cfg_t          cfg,
    output logic [DATA_W-1:0] next_val,
    output logic              fire
);
    logic [DATA_W-1:0] post;

    // Fold the written data into the current content.
    always_comb begin
        unique case (cfg.mode)
            MODE_OR:  post = cur | wdata;
            MODE_ADD: post = cur + wdata;
            default:  post = wdata;
        endcase
    end

    // Evaluate the configured condition on the updated value.
    always_comb begin
        unique case (cfg.cond)
            COND_DOORBELL: fire = 1'b1;
            COND_EQUAL:    fire = (post == trig);
            COND_RENDEZ:   fire = (post == trig);
            default:       fire = (post >= trig);
        endcase
    end

    // A rendezvous that fires empties the mailbox.
    always_comb begin
        next_val = (fire && cfg.cond == COND_RENDEZ) ? '0 : post;
    end
endmodule

// File: rtl/mbx_pending.sv
// Sticky pending-interrupt vector. Each bit is set by its trigger and cleared
// by an acknowledge mask; a simultaneous set overrides the clear.
// Assumes: set_vec is at most one-hot and is only driven by content writes.
module mbx_pending #(
    parameter int NUM_BOX = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BOX-1:0] set_vec,
    input  logic               ack_valid,
    input  logic [NUM_BOX-1:0] ack_bits,
    output logic [NUM_BOX-1:0] pend_q
);
    for (genvar g = 0; g < NUM_BOX; g++) begin : g_bit
        // Hold, clear on acknowledge, set on trigger (set has priority).
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[g] <= 1'b0;
            else if (set_vec[g]) pend_q[g] <= 1'b1;
            else if (ack_valid && ack_bits[g]) pend_q[g] <= 1'b0;
        end
    end

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

    assert_ack_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> ((pend_q & $past(ack_bits & ~set_vec)) == '0));
endmodule

// File: rtl/smart_mailbox_irq.sv
// Top of the smart mailbox interrupt controller: holds content, trigger and
// configuration storage, performs bus reads and writes, and feeds triggers
// into the pending vector.
// Assumes: one bus access per cycle; read data registered (1-cycle latency).
module smart_mailbox_irq
    import mbx_pkg::*;
#(
    parameter int NUM_BOX = 128,
    parameter int DATA_W  = 64,
    localparam int IDX_W  = $clog2(NUM_BOX),
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               ack_valid,
    input  logic [NUM_BOX-1:0] ack_bits,
    output logic [NUM_BOX-1:0] irq_pending
);
    localparam int CFG_W = $bits(box_cfg_t);

    logic [DATA_W-1:0] box_q  [NUM_BOX];
    logic [DATA_W-1:0] trig_q [NUM_BOX];
    box_cfg_t          cfg_q  [NUM_BOX];

    logic [IDX_W-1:0]  idx_s;
    region_e           region_s;
    logic              content_wr, trigger_wr, config_wr, rd_s;
    logic [DATA_W-1:0] cur_sel, trig_sel, upd_next;
    box_cfg_t          cfg_sel;
    logic              upd_fire;
    logic [NUM_BOX-1:0] set_vec;
    logic [DATA_W-1:0] rdata_q;

    mbx_decode #(.NUM_BOX(NUM_BOX)) u_decode (
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .idx        (idx_s),
        .region     (region_s),
        .content_wr (content_wr),
        .trigger_wr (trigger_wr),
        .config_wr  (config_wr),
        .rd         (rd_s)
    );

    // Select the addressed mailbox's state.
    always_comb begin
        cur_sel  = box_q[idx_s];
        trig_sel = trig_q[idx_s];
        cfg_sel  = cfg_q[idx_s];
    end

    mbx_update #(.DATA_W(DATA_W)) u_update (
        .cur      (cur_sel),
        .wdata    (bus_wdata),
        .trig     (trig_sel),
        .cfg      (cfg_sel),
        .next_val (upd_next),
        .fire     (upd_fire)
    );

    // One set line per mailbox, raised only by a content write that fires.
    for (genvar g = 0; g < NUM_BOX; g++) begin : g_set
        assign set_vec[g] = content_wr && upd_fire && (idx_s == IDX_W'(g));
    end

    mbx_pending #(.NUM_BOX(NUM_BOX)) u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .ack_valid (ack_valid),
        .ack_bits  (ack_bits),
        .pend_q    (irq_pending)
    );

    // Update mailbox storage from bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BOX; i++) begin
                box_q[i]  <= '0;
                trig_q[i] <= '0;
                cfg_q[i]  <= '0;
            end
        end else begin
            if (content_wr) box_q[idx_s]  <= upd_next;
            if (trigger_wr) trig_q[idx_s] <= bus_wdata;
            if (config_wr)  cfg_q[idx_s]  <= box_cfg_t'(bus_wdata[CFG_W-1:0]);
        end
    end

    // Register read data for the addressed region; hold between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (rd_s) begin
            unique case (region_s)
                RGN_CONTENT: rdata_q <= cur_sel;
                RGN_TRIGGER: rdata_q <= trig_sel;
                RGN_CONFIG:  rdata_q <= {{(DATA_W-CFG_W){1'b0}}, cfg_sel};
                default:     rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;

    assert_pend_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_pending & ~$past(irq_pending)) != '0) |-> $past(content_wr));

    assert_rendez_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (content_wr && upd_fire && cfg_sel.cond == COND_RENDEZ)
        |=> (box_q[$past(idx_s)] == '0));

    assert_read_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_s && region_s == RGN_CONTENT && !bus_addr[ADDR_W-1])
        |=> (bus_rdata == $past(cur_sel)));

    assert_read_keeps_pending_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_s && !ack_valid) |=> $stable(irq_pending));
endmodule

// File: tb/tb_smart_mailbox_irq.sv
`timescale 1ns/1ps
module tb_smart_mailbox_irq;
    localparam int NB = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [8:0]    bus_addr = '0;
    logic [63:0]   bus_wdata = '0;
    logic [63:0]   bus_rdata;
    logic          ack_valid = 1'b0;
    logic [NB-1:0] ack_bits = '0;
    logic [NB-1:0] irq_pending;

    int checks = 0;
    int errors = 0;

    logic [63:0]   m_data [NB];
    logic [63:0]   m_trig [NB];
    logic [1:0]    m_mode [NB];
    logic [1:0]    m_cond [NB];
    logic [NB-1:0] m_pend;

    always #2 clk = ~clk;

    smart_mailbox_irq dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_valid(ack_valid), .ack_bits(ack_bits), .irq_pending(irq_pending)
    );

    task automatic chk(input logic ok, input string req, input logic [NB-1:0] act,
                       input logic [NB-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected read value per region, from the address map in R2.
    function automatic logic [63:0] exp_read(input logic [1:0] rg, input int ix);
        case (rg)
            2'd0:    return m_data[ix];
            2'd1:    return m_trig[ix];
            2'd2:    return {60'd0, m_cond[ix], m_mode[ix]};
            default: return 64'd0;
        endcase
    endfunction

    // One bus cycle, entered and left on a falling edge; model then compare.
    task automatic cyc(input logic en, input logic we, input logic [1:0] rg, input int ix,
                       input logic [63:0] wd, input logic av, input logic [NB-1:0] ab,
                       input string req);
        logic [63:0]   exp_rd, post;
        logic          rd_chk, fire;
        logic [NB-1:0] setv;
        bus_en = en; bus_we = we; bus_addr = {rg, 7'(ix)}; bus_wdata = wd;
        ack_valid = av; ack_bits = ab;
        setv = '0;
        rd_chk = en && !we;
        exp_rd = exp_read(rg, ix);
        if (en && we) begin
            case (rg)
                2'd0: begin
                    case (m_mode[ix])
                        2'b01:   post = m_data[ix] | wd;
                        2'b10:   post = m_data[ix] + wd;
                        default: post = wd;
                    endcase
                    case (m_cond[ix])
                        2'b00:   fire = 1'b1;
                        2'b11:   fire = (post >= m_trig[ix]);
                        default: fire = (post == m_trig[ix]);
                    endcase
                    m_data[ix] = (fire && m_cond[ix] == 2'b10) ? 64'd0 : post;
                    if (fire) setv[ix] = 1'b1;
                end
                2'd1: m_trig[ix] = wd;
                2'd2: begin m_mode[ix] = wd[1:0]; m_cond[ix] = wd[3:2]; end
                default: ;
            endcase
        end
        if (av) m_pend = m_pend & ~ab;
        m_pend = m_pend | setv;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; ack_valid = 1'b0; ack_bits = '0;
        chk(irq_pending === m_pend, {req, " pending"}, irq_pending, m_pend);
        if (rd_chk) chk(bus_rdata === exp_rd, {req, " rdata"}, NB'(bus_rdata), NB'(exp_rd));
    endtask

    task automatic wr(input logic [1:0] rg, input int ix, input logic [63:0] wd, input string req);
        cyc(1'b1, 1'b1, rg, ix, wd, 1'b0, '0, req);
    endtask

    task automatic rdc(input logic [1:0] rg, input int ix, input string req);
        cyc(1'b1, 1'b0, rg, ix, 64'd0, 1'b0, '0, req);
    endtask

    task automatic ack(input logic [NB-1:0] ab, input string req);
        cyc(1'b0, 1'b0, 2'd0, 0, 64'd0, 1'b1, ab, req);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) begin
            m_data[i] = '0; m_trig[i] = '0; m_mode[i] = '0; m_cond[i] = '0;
        end
        m_pend = '0;
        void'($urandom(32'd20240722));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(irq_pending === '0, "R1 pending", irq_pending, '0);
        chk(bus_rdata === 64'd0, "R1 rdata", NB'(bus_rdata), '0);
        rdc(2'd0, 9, "R1 content");
        rdc(2'd1, 9, "R1 trigger");
        rdc(2'd2, 127, "R1 config");

        // R3 + R8: replace mode, equality not met, then met
        wr(2'd2, 0, 64'h4, "R2 config write");           // cond 01, mode 00
        wr(2'd1, 0, 64'd99, "R11 trigger write");
        wr(2'd0, 0, 64'd5, "R3 replace no fire");
        rdc(2'd0, 0, "R3 replace value");
        wr(2'd0, 0, 64'd99, "R8 equal fires");
        rdc(2'd2, 0, "R2 config readback");

        // R4 + R10: OR mode with threshold
        wr(2'd2, 1, 64'hD, "R2 config write");           // cond 11, mode 01
        wr(2'd1, 1, 64'h30, "R11 trigger write");
        wr(2'd0, 1, 64'h10, "R4 OR below threshold");
        wr(2'd0, 1, 64'h20, "R10 OR reaches threshold");
        rdc(2'd0, 1, "R4 OR value");

        // R10: unsigned compare with top bit set
        wr(2'd2, 2, 64'hC, "R2 config write");           // cond 11, mode 00
        wr(2'd1, 2, 64'd5, "R11 trigger write");
        wr(2'd0, 2, 64'h8000_0000_0000_0000, "R10 unsigned large fires");

        // R5 + R7: add mode wraps, doorbell fires every write
        wr(2'd2, 3, 64'h2, "R2 config write");           // cond 00, mode 10
        wr(2'd0, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R7 doorbell");
        ack(NB'(1) << 3, "R12 ack clears");
        wr(2'd0, 3, 64'd2, "R5 add wrap doorbell");
        rdc(2'd0, 3, "R5 wrapped sum");

        // R9: rendezvous counts to 3 then empties
        wr(2'd2, 5, 64'hA, "R2 config write");           // cond 10, mode 10
        wr(2'd1, 5, 64'd3, "R11 trigger write");
        wr(2'd0, 5, 64'd1, "R9 count 1");
        wr(2'd0, 5, 64'd1, "R9 count 2");
        wr(2'd0, 5, 64'd1, "R9 count 3 fires");
        rdc(2'd0, 5, "R9 content cleared");

        // R6: spare mode behaves as replace
        wr(2'd2, 6, 64'h3, "R2 config write");           // cond 00, mode 11
        wr(2'd0, 6, 64'd7, "R6 spare mode");
        wr(2'd0, 6, 64'd4, "R6 spare mode replace");
        rdc(2'd0, 6, "R6 spare mode value");

        // R11: trigger/config writes cannot fire, even with a doorbell mailbox
        ack('1, "R12 ack all");
        wr(2'd1, 6, 64'd4, "R11 trigger write no fire");
        wr(2'd2, 6, 64'h3, "R11 config write no fire");
        rdc(2'd0, 6, "R11 read no fire");
        wr(2'd3, 6, 64'd1, "R2 region 3 write ignored");
        rdc(2'd3, 6, "R2 region 3 reads zero");
        rdc(2'd0, 6, "R2 content untouched by region 3");

        // R12: set and acknowledge of the same bit on one edge
        wr(2'd2, 4, 64'h0, "R2 config write");
        cyc(1'b1, 1'b1, 2'd0, 4, 64'd1, 1'b1, NB'(1) << 4, "R12 set wins");
        ack(NB'(1) << 4, "R12 ack after collision");

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int          op, ix;
            logic [63:0] v;
            logic        av;
            logic [NB-1:0] ab;
            op = $urandom_range(0, 9);
            ix = ($urandom_range(0, 7) == 0) ? $urandom_range(0, NB-1) : $urandom_range(0, 7);
            v  = ($urandom_range(0, 3) == 0) ? {$urandom, $urandom} : 64'($urandom_range(0, 6));
            av = ($urandom_range(0, 2) == 0);
            ab = NB'($urandom_range(0, 255));
            if (op < 5)      cyc(1'b1, 1'b1, 2'd0, ix, v, av, ab, "R12 random content write");
            else if (op == 5) cyc(1'b1, 1'b1, 2'd1, ix, 64'($urandom_range(0, 8)), av, ab, "R11 random trigger write");
            else if (op == 6) cyc(1'b1, 1'b1, 2'd2, ix, 64'($urandom_range(0, 15)), av, ab, "R11 random config write");
            else if (op == 7) cyc(1'b1, 1'b0, 2'($urandom_range(0, 3)), ix, 64'd0, av, ab, "R13 random read");
            else              cyc(1'b0, 1'b0, 2'd0, 0, 64'd0, 1'b1, ab, "R12 random ack");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule